// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block keeps the two error counters of a CAN node and works out which fault-confinement state the node is in. The protocol engine sends it single-cycle strobes: a receive error, a transmit error, a good reception, a good transmission and a detected bus-idle recovery sequence. Each error strobe comes with a weight input that picks an increment of 1 or 8. The block applies the counting rules to these strobes. It then shows the counters and three state flags (warning, error passive, bus-off) on plain status pins. It also packs them into one 32-bit status word for readback.

The receive counter is 8 bits wide and saturates. The transmit counter is 9 bits wide, and only its low byte is visible. A good reception while the receive counter is above 128 reloads it to 120 instead of counting down. Bus-off is entered when the transmit counter passes 255. Both counters are then frozen until a recovery strobe arrives. The recovery strobe clears both counters and returns the node to error active. None of the pins carries a data stream, so every pin is a plain control or status signal with no handshake. Strobes are sampled on each rising clock edge. The outputs are valid one cycle after the edge that consumed a strobe.

Top module: `fc_err_tracker`

## Requirements
- R1: After reset, both counters, all three flags and the whole status word are zero.
- R2: A receive-error strobe adds 8 to the receive counter when its heavy-weight input is 1, and adds 1 when that input is 0.
- R3: A good-reception strobe reloads the receive counter to 120 if it is above 128. Otherwise the strobe lowers the counter by 1, and a counter at 0 stays at 0.
- R4: The receive counter saturates at 255 and never wraps.
- R5: A transmit-error strobe adds 8 to the transmit counter when its heavy-weight input is 1, and adds 1 when that input is 0. A good-transmission strobe lowers the counter by 1, and a counter at 0 stays at 0.
- R6: When an error strobe and a success strobe for the same counter arrive in one cycle, only the increment is applied.
- R7: The warning flag is 1 while either counter is 96 or higher.
- R8: The error-passive flag is 1 when either counter exceeds 127 and the node is not in bus-off. It is 0 in bus-off.
- R9: The bus-off flag is 1 while the 9-bit transmit counter exceeds 255. The transmit output shows only bits 7:0 of that counter.
- R10: While in bus-off, all four error and success strobes leave both counters unchanged.
- R11: A recovery strobe in bus-off clears both counters to 0, which returns the node to error active. A recovery strobe outside bus-off has no effect.
- R12: Status word layout: bits 31:24 hold the receive counter and bits 23:16 hold the transmit low byte. Bit 2 is bus-off, bit 1 is error passive and bit 0 is warning. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_err_stb | input | 1 | Receive error event |
| rx_err_heavy | input | 1 | 1: receive error weight 8, 0: weight 1 |
| rx_ok_stb | input | 1 | Good reception event |
| tx_err_stb | input | 1 | Transmit error event |
| tx_err_heavy | input | 1 | 1: transmit error weight 8, 0: weight 1 |
| tx_ok_stb | input | 1 | Good transmission event |
| recover_stb | input | 1 | Bus-idle recovery sequence observed |
| rx_cnt | output | 8 | Receive error counter |
| tx_cnt_lo | output | 8 | Low byte of the transmit error counter |
| warn | output | 1 | Warning level reached |
| err_passive | output | 1 | Node is error passive |
| bus_off | output | 1 | Node is bus-off |
| status_word | output | 32 | Packed status readback |

## Verification
An increment and a decrement of the same counter can fall in the same cycle. So can a bus-off freeze and a counting strobe. The bench raises the error and success strobes of one counter in a single cycle and expects only the increment. In bus-off it raises receive and transmit strobes together and expects both counters to hold. It then checks that a recovery strobe alone clears both counters.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;

  localparam int FC_RX_W        = 8;
  localparam int FC_TX_W        = 9;
  localparam int FC_STEP_HEAVY  = 8;
  localparam int FC_STEP_LIGHT  = 1;
  localparam int FC_RELOAD_OVER = 128;
  localparam int FC_RELOAD_VAL  = 120;
  localparam int FC_WARN_AT     = 96;
  localparam int FC_PASSIVE_OVR = 127;
  localparam int FC_BUSOFF_OVR  = 255;
endpackage

// File: rtl/fc_err_counter.sv
module fc_err_counter #(
  parameter int WIDTH       = 8,
  parameter int STEP_HEAVY  = 8,
  parameter int STEP_LIGHT  = 1,
  parameter bit RELOAD_EN   = 1'b0,
  parameter int RELOAD_OVER = 128,
  parameter int RELOAD_VAL  = 120
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             heavy,
  input  logic             dec,
  input  logic             clr,
  output logic [WIDTH-1:0] cnt
);
  localparam int MAXV = (1 << WIDTH) - 1;

  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] inc_val;
  logic [WIDTH-1:0] down_val;
  logic [WIDTH-1:0] dec_val;

  assign sum      = {1'b0, cnt} + (heavy ? (WIDTH+1)'(STEP_HEAVY) : (WIDTH+1)'(STEP_LIGHT));
  assign inc_val  = (sum > (WIDTH+1)'(MAXV)) ? WIDTH'(MAXV) : sum[WIDTH-1:0];
  assign down_val = (cnt == '0) ? '0 : cnt - 1'b1;

  generate
    if (RELOAD_EN) begin : g_reload
      assign dec_val = (cnt > WIDTH'(RELOAD_OVER)) ? WIDTH'(RELOAD_VAL) : down_val;
    end else begin : g_plain
      assign dec_val = down_val;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (inc)    cnt <= inc_val;
    else if (dec)    cnt <= dec_val;
  end

  // R4: an increment never makes the counter smaller (no wrap)
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (cnt >= $past(cnt)));

  // R6: increment wins over a simultaneous decrement
  p_inc_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec && !clr && cnt < WIDTH'(MAXV)) |=> (cnt > $past(cnt)));

  // R5: a decrement at zero stays at zero
  p_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && dec && !clr && cnt == '0) |=> (cnt == '0));

  // R3: reload on success above the threshold
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (RELOAD_EN && !inc && dec && !clr && cnt > WIDTH'(RELOAD_OVER))
      |=> (cnt == WIDTH'(RELOAD_VAL)));
endmodule

// File: rtl/fc_state_decode.sv
module fc_state_decode
  import fc_pkg::*;
#(
  parameter int RX_W        = FC_RX_W,
  parameter int TX_W        = FC_TX_W,
  parameter int WARN_AT     = FC_WARN_AT,
  parameter int PASSIVE_OVR = FC_PASSIVE_OVR,
  parameter int BUSOFF_OVR  = FC_BUSOFF_OVR
) (
  input  logic [RX_W-1:0] rx_cnt,
  input  logic [TX_W-1:0] tx_cnt,
  output fc_state_e       state,
  output logic            warn
);
  logic rx_passive, tx_passive, tx_busoff;

  assign rx_passive = rx_cnt > RX_W'(PASSIVE_OVR);
  assign tx_passive = tx_cnt > TX_W'(PASSIVE_OVR);
  assign tx_busoff  = tx_cnt > TX_W'(BUSOFF_OVR);
  assign warn       = (rx_cnt >= RX_W'(WARN_AT)) || (tx_cnt >= TX_W'(WARN_AT));

  always_comb begin
    if (tx_busoff)                    state = FC_BUSOFF;
    else if (rx_passive || tx_passive) state = FC_PASSIVE;
    else                              state = FC_ACTIVE;
  end
endmodule

// File: rtl/fc_err_tracker.sv
module fc_err_tracker
  import fc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_err_stb,
  input  logic        rx_err_heavy,
  input  logic        rx_ok_stb,
  input  logic        tx_err_stb,
  input  logic        tx_err_heavy,
  input  logic        tx_ok_stb,
  input  logic        recover_stb,
  output logic [7:0]  rx_cnt,
  output logic [7:0]  tx_cnt_lo,
  output logic        warn,
  output logic        err_passive,
  output logic        bus_off,
  output logic [31:0] status_word
);
  logic [FC_RX_W-1:0] rx_q;
  logic [FC_TX_W-1:0] tx_q;
  fc_state_e          state;
  logic               live, clr;

  assign live = !bus_off;
  assign clr  = bus_off && recover_stb;

  fc_err_counter #(
    .WIDTH(FC_RX_W), .STEP_HEAVY(FC_STEP_HEAVY), .STEP_LIGHT(FC_STEP_LIGHT),
    .RELOAD_EN(1'b1), .RELOAD_OVER(FC_RELOAD_OVER), .RELOAD_VAL(FC_RELOAD_VAL)
  ) u_rx (
    .clk(clk), .rst_n(rst_n),
    .inc(rx_err_stb && live), .heavy(rx_err_heavy),
    .dec(rx_ok_stb && live), .clr(clr), .cnt(rx_q)
  );

  fc_err_counter #(
    .WIDTH(FC_TX_W), .STEP_HEAVY(FC_STEP_HEAVY), .STEP_LIGHT(FC_STEP_LIGHT),
    .RELOAD_EN(1'b0), .RELOAD_OVER(FC_RELOAD_OVER), .RELOAD_VAL(FC_RELOAD_VAL)
  ) u_tx (
    .clk(clk), .rst_n(rst_n),
    .inc(tx_err_stb && live), .heavy(tx_err_heavy),
    .dec(tx_ok_stb && live), .clr(clr), .cnt(tx_q)
  );

  fc_state_decode u_dec (
    .rx_cnt(rx_q), .tx_cnt(tx_q), .state(state), .warn(warn)
  );

  assign rx_cnt      = rx_q;
  assign tx_cnt_lo   = tx_q[7:0];
  assign err_passive = (state == FC_PASSIVE);
  assign bus_off     = (state == FC_BUSOFF);
  assign status_word = {rx_q, tx_q[7:0], 13'd0, bus_off, err_passive, warn};

  // R10: counters frozen in bus-off unless recovering
  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && !recover_stb) |=> ($stable(rx_q) && $stable(tx_q)));

  // R11: recovery clears both counters and leaves bus-off
  p_recover_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && recover_stb) |=> (rx_q == '0 && tx_q == '0 && !bus_off));

  // R8: receive counter above 127 outside bus-off means passive
  p_passive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_off && rx_q > 8'd127) |-> err_passive);

  // R9: entering bus-off only happens from a transmit error
  p_busoff_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_off) |-> $past(tx_err_stb));
endmodule

// File: tb/tb_fc_err_tracker.sv
module tb_fc_err_tracker;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_err_stb = 0, rx_err_heavy = 0, rx_ok_stb = 0;
  logic tx_err_stb = 0, tx_err_heavy = 0, tx_ok_stb = 0, recover_stb = 0;
  logic [7:0]  rx_cnt, tx_cnt_lo;
  logic        warn, err_passive, bus_off;
  logic [31:0] status_word;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fc_err_tracker dut (
    .clk(clk), .rst_n(rst_n),
    .rx_err_stb(rx_err_stb), .rx_err_heavy(rx_err_heavy), .rx_ok_stb(rx_ok_stb),
    .tx_err_stb(tx_err_stb), .tx_err_heavy(tx_err_heavy), .tx_ok_stb(tx_ok_stb),
    .recover_stb(recover_stb),
    .rx_cnt(rx_cnt), .tx_cnt_lo(tx_cnt_lo), .warn(warn),
    .err_passive(err_passive), .bus_off(bus_off), .status_word(status_word)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ev(input logic re, input logic rh, input logic ro,
                    input logic te, input logic th, input logic to, input logic rc);
    @(negedge clk);
    rx_err_stb = re; rx_err_heavy = rh; rx_ok_stb = ro;
    tx_err_stb = te; tx_err_heavy = th; tx_ok_stb = to; recover_stb = rc;
    @(negedge clk);
    rx_err_stb = 0; rx_err_heavy = 0; rx_ok_stb = 0;
    tx_err_stb = 0; tx_err_heavy = 0; tx_ok_stb = 0; recover_stb = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic rx_heavy(input int n);
    for (int i = 0; i < n; i++) ev(1,1,0,0,0,0,0);
  endtask

  task automatic tx_heavy(input int n);
    for (int i = 0; i < n; i++) ev(0,0,0,1,1,0,0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rx_cnt", rx_cnt, 0);
    chk("R1 tx_cnt_lo", tx_cnt_lo, 0);
    chk("R1 flags", {warn, err_passive, bus_off}, 0);
    chk("R1 status_word", status_word, 0);
  endtask

  task automatic t_rx_basic();
    do_reset();
    ev(1,0,0,0,0,0,0); chk("R2 light rx", rx_cnt, 1);
    ev(1,1,0,0,0,0,0); chk("R2 heavy rx", rx_cnt, 9);
    ev(0,0,1,0,0,0,0); chk("R3 rx dec", rx_cnt, 8);
    ev(1,0,1,0,0,0,0); chk("R6 rx inc wins", rx_cnt, 9);
    ev(0,0,0,1,1,0,0);
    chk("R12 status", status_word, 32'h0908_0000);
  endtask

  task automatic t_rx_reload();
    do_reset();
    rx_heavy(17);
    chk("R2 rx 136", rx_cnt, 136);
    chk("R8 rx passive", err_passive, 1);
    chk("R7 warn rx", warn, 1);
    chk("R12 status passive", status_word, 32'h8800_0003);
    ev(0,0,1,0,0,0,0); chk("R3 reload", rx_cnt, 120);
    chk("R8 active again", err_passive, 0);
    rx_heavy(1); chk("R2 rx 128", rx_cnt, 128);
    ev(0,0,1,0,0,0,0); chk("R3 dec at 128", rx_cnt, 127);
    chk("R8 127 active", err_passive, 0);
    for (int i = 0; i < 3; i++) ev(0,0,1,0,0,0,0);
    chk("R3 dec below", rx_cnt, 124);
  endtask

  task automatic t_rx_sat();
    do_reset();
    rx_heavy(31); ev(1,0,0,0,0,0,0); ev(1,0,0,0,0,0,0);
    chk("R4 rx 250", rx_cnt, 250);
    rx_heavy(1); chk("R4 saturate heavy", rx_cnt, 255);
    ev(1,0,0,0,0,0,0); chk("R4 saturate light", rx_cnt, 255);
    chk("R9 no busoff from rx", bus_off, 0);
  endtask

  task automatic t_tx_basic();
    do_reset();
    ev(0,0,0,0,0,1,0); chk("R5 tx floor", tx_cnt_lo, 0);
    ev(0,0,0,0,0,0,0);
    ev(0,0,1,0,0,0,0); chk("R3 rx floor", rx_cnt, 0);
    tx_heavy(1); chk("R5 tx heavy", tx_cnt_lo, 8);
    ev(0,0,0,1,0,0,0); chk("R5 tx light", tx_cnt_lo, 9);
    ev(0,0,0,0,0,1,0); chk("R5 tx dec", tx_cnt_lo, 8);
    ev(0,0,0,1,0,1,0); chk("R6 tx inc wins", tx_cnt_lo, 9);
  endtask

  task automatic t_warn();
    do_reset();
    tx_heavy(11);
    for (int i = 0; i < 7; i++) ev(0,0,0,1,0,0,0);
    chk("R5 tx 95", tx_cnt_lo, 95);
    chk("R7 warn at 95", warn, 0);
    ev(0,0,0,1,0,0,0); chk("R7 warn at 96", warn, 1);
    ev(0,0,0,0,0,1,0); chk("R7 warn off at 95", warn, 0);
  endtask

  task automatic t_busoff();
    do_reset();
    rx_heavy(2);
    tx_heavy(16); chk("R8 tx 128 passive", err_passive, 1);
    tx_heavy(15); chk("R9 tx 248", tx_cnt_lo, 248);
    chk("R9 not yet busoff", bus_off, 0);
    tx_heavy(1);
    chk("R9 busoff", bus_off, 1);
    chk("R9 low byte", tx_cnt_lo, 0);
    chk("R8 passive off in busoff", err_passive, 0);
    chk("R12 busoff status", status_word, 32'h1000_0005);
    ev(1,1,0,0,0,1,0);
    chk("R10 rx frozen", rx_cnt, 16);
    chk("R10 tx frozen", tx_cnt_lo, 0);
    chk("R10 still busoff", bus_off, 1);
    ev(0,0,1,1,1,0,0);
    chk("R10 rx frozen ok", rx_cnt, 16);
    chk("R10 busoff held", bus_off, 1);
    ev(0,0,0,0,0,0,1);
    chk("R11 rx cleared", rx_cnt, 0);
    chk("R11 tx cleared", tx_cnt_lo, 0);
    chk("R11 left busoff", {warn, err_passive, bus_off}, 0);
  endtask

  task automatic t_recover_ignored();
    do_reset();
    for (int i = 0; i < 5; i++) ev(1,0,0,0,0,0,0);
    tx_heavy(1);
    ev(0,0,0,0,0,0,1);
    chk("R11 ignored rx", rx_cnt, 5);
    chk("R11 ignored tx", tx_cnt_lo, 8);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_rx_basic();
    t_rx_reload();
    t_rx_sat();
    t_tx_basic();
    t_warn();
    t_busoff();
    t_recover_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule